// File: doc/BRIEF.md
# Adaptive Three-Color Pixel Classifier

This block sorts a stream of 24-bit RGB pixels, one per valid cycle, into three color classes: reddish, whitish and blackish. For each accepted pixel it returns a 3-bit flag word one cycle later. The flags are not exclusive: a pixel can be both whitish and blackish, or reddish and whitish.

The absolute color thresholds follow the overall brightness of the scene. At each frame boundary the host presents the mean pixel value of the previous frame together with a one-cycle `frame_start` pulse. A small state machine with three reachable states stores that mean and records whether the scene counts as too dark, too light or normal.

- State `CM_NONE` (code 00) is the state after reset and applies no correction.
- State `CM_DARKEN` (code 01) pulls the thresholds down by 125 minus the mean.
- State `CM_LIGHTEN` (code 10) pushes the thresholds up by the mean minus 150.
- Code 11 (`CM_SPARE`) is never entered. It also yields zero correction.

The state machine has the following transitions, all taken on `frame_start`:

- "darken" is taken when the mean is below 125.
- "lighten" is taken when the mean is above 150.
- "neutral" is taken otherwise.

Without `frame_start` the state machine holds its state. The pixels themselves are never rescaled.

Top module: `tricolor_pixel_sorter`

## Requirements
- R1: Flag bit 0 (reddish) is set when R is greater than the red threshold, and R exceeds G by more than 17, and R exceeds B by more than 17. The margin of 17 is never adjusted. With no correction, the red threshold is 77.
- R2: Flag bit 1 (whitish) is set when R, G and B are each greater than the white threshold. With no correction, the white threshold is 108.
- R3: Flag bit 2 (blackish) is set when R, G and B are each less than the black threshold. With no correction, the black threshold is 122. Bits 1 and 2 may be set together.
- R4: A `frame_start` pulse latches `avg_in` and chooses the mode from it:
  - below 125 gives darken;
  - above 150 gives lighten;
  - 125 to 150 inclusive gives no correction.

  The chosen mode applies to pixels presented from the following cycle onward. Without the pulse, the mode and the stored mean do not change.
- R5: In darken mode, each of the three thresholds is reduced by (125 − mean). A result below 0 is clamped to 0.
- R6: In lighten mode, each of the three thresholds is increased by (mean − 150). A result above 255 is clamped to 255.
- R7: `flags_valid` equals `pix_valid` delayed by exactly one clock. `flags` carries the classification of the pixel presented in the previous cycle. `flags` is zero whenever `flags_valid` is low.
- R8: After reset, the mode is no correction, and `flags_valid` and `flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that latches the mean of the previous frame |
| avg_in | input | 8 | Mean pixel value of the previous frame |
| pix_valid | input | 1 | Pixel on `pix_r`/`pix_g`/`pix_b` is valid |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| flags_valid | output | 1 | `flags` holds a result |
| flags | output | 3 | Bit 0 reddish, bit 1 whitish, bit 2 blackish |

## Verification
The classifier is exercised in several brightness modes, each entered through a `frame_start` pulse:

- a neutral frame;
- darken frames with means of 100 and 0, where the second clamps the red, white and black thresholds to 0;
- lighten frames with means of 200 and 255;
- frames with means of exactly 125 and 150, which must stay neutral.

In each mode, pixels placed one step on either side of every threshold and of the red margin separate strict from non-strict comparisons. They also show whether the margin is shifted along with the absolute thresholds. A pseudo-random pixel sweep with gaps in `pix_valid` compares every cycle against a behavioural model. This exposes wrong bit positions, lost valid bubbles and a mode that changes in the middle of a frame.

// File: rtl/tricolor_pkg.sv
package tricolor_pkg;

    // Brightness correction mode; the encoding is the correction select code.
    typedef enum logic [1:0] {
        CM_NONE    = 2'b00,
        CM_DARKEN  = 2'b01,
        CM_LIGHTEN = 2'b10,
        CM_SPARE   = 2'b11
    } corr_mode_e;

    // Flag word bit positions.
    localparam int FLAG_RED   = 0;
    localparam int FLAG_WHITE = 1;
    localparam int FLAG_BLACK = 2;
    localparam int NUM_FLAGS  = 3;

endpackage

// File: rtl/brightness_mode_fsm.sv
module brightness_mode_fsm
    import tricolor_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int DARK_LIM  = 125,
    parameter int LIGHT_LIM = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [PIX_W-1:0] avg_in,
    output corr_mode_e       mode,
    output logic [PIX_W-1:0] corr
);

    localparam logic [PIX_W-1:0] DARK_L  = PIX_W'(DARK_LIM);
    localparam logic [PIX_W-1:0] LIGHT_L = PIX_W'(LIGHT_LIM);

    corr_mode_e       state_q, state_d;
    logic [PIX_W-1:0] avg_q;

    // State register and stored mean
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CM_NONE;
            avg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frame_start) begin
                avg_q <= avg_in;
            end
        end
    end

    // Transitions: darken / lighten / neutral, evaluated only on frame_start
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            if (avg_in < DARK_L) begin
                state_d = CM_DARKEN;
            end else if (avg_in > LIGHT_L) begin
                state_d = CM_LIGHTEN;
            end else begin
                state_d = CM_NONE;
            end
        end
    end

    // Outputs: correction select multiplexer
    always_comb begin
        corr = '0;
        unique case (state_q)
            CM_NONE:    corr = '0;
            CM_DARKEN:  corr = DARK_L - avg_q;
            CM_LIGHTEN: corr = avg_q - LIGHT_L;
            CM_SPARE:   corr = '0;
        endcase
    end

    assign mode = state_q;

    // R4: the mode only moves on a frame boundary
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(state_q) && $stable(avg_q));

    // R4: a dark mean selects darken on the next cycle
    p_dark_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && avg_in < DARK_L) |=> state_q == CM_DARKEN);

    // R4: a mean inside the band selects no correction
    p_band_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && avg_in >= DARK_L && avg_in <= LIGHT_L) |=> state_q == CM_NONE);

    // R4: the spare code is never entered
    p_no_spare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != CM_SPARE);

endmodule

// File: rtl/threshold_shift.sv
module threshold_shift
    import tricolor_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int RED_BASE   = 77,
    parameter int WHITE_BASE = 108,
    parameter int BLACK_BASE = 122
) (
    input  logic             clk,
    input  logic             rst_n,
    input  corr_mode_e       mode,
    input  logic [PIX_W-1:0] corr,
    output logic [PIX_W-1:0] thr_red,
    output logic [PIX_W-1:0] thr_white,
    output logic [PIX_W-1:0] thr_black
);

    localparam int SUM_W   = PIX_W + 2;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    logic [PIX_W-1:0] base_arr [NUM_FLAGS];
    logic [PIX_W-1:0] thr_arr  [NUM_FLAGS];

    assign base_arr[FLAG_RED]   = PIX_W'(RED_BASE);
    assign base_arr[FLAG_WHITE] = PIX_W'(WHITE_BASE);
    assign base_arr[FLAG_BLACK] = PIX_W'(BLACK_BASE);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_thr
        logic signed [SUM_W-1:0] sum;
        always_comb begin
            sum = $signed({2'b00, base_arr[i]});
            unique case (mode)
                CM_LIGHTEN: sum = $signed({2'b00, base_arr[i]}) + $signed({2'b00, corr});
                CM_DARKEN:  sum = $signed({2'b00, base_arr[i]}) - $signed({2'b00, corr});
                CM_NONE:    sum = $signed({2'b00, base_arr[i]});
                CM_SPARE:   sum = $signed({2'b00, base_arr[i]});
            endcase
            if (sum < 0) begin
                thr_arr[i] = '0;
            end else if (sum > SUM_W'(PIX_MAX)) begin
                thr_arr[i] = PIX_W'(PIX_MAX);
            end else begin
                thr_arr[i] = sum[PIX_W-1:0];
            end
        end
    end

    assign thr_red   = thr_arr[FLAG_RED];
    assign thr_white = thr_arr[FLAG_WHITE];
    assign thr_black = thr_arr[FLAG_BLACK];

    // R5: darkening never raises a threshold
    p_dark_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == CM_DARKEN |-> thr_red <= PIX_W'(RED_BASE) && thr_black <= PIX_W'(BLACK_BASE));

    // R6: lightening never lowers a threshold
    p_light_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == CM_LIGHTEN |-> thr_white >= PIX_W'(WHITE_BASE) && thr_red >= PIX_W'(RED_BASE));

endmodule

// File: rtl/color_match.sv
module color_match
    import tricolor_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int RED_MARGIN = 17
) (
    input  logic [PIX_W-1:0]     r,
    input  logic [PIX_W-1:0]     g,
    input  logic [PIX_W-1:0]     b,
    input  logic [PIX_W-1:0]     thr_red,
    input  logic [PIX_W-1:0]     thr_white,
    input  logic [PIX_W-1:0]     thr_black,
    output logic [NUM_FLAGS-1:0] hit
);

    localparam logic [PIX_W:0] MARGIN = (PIX_W + 1)'(RED_MARGIN);

    logic [PIX_W:0] g_plus, b_plus;

    always_comb begin
        g_plus = {1'b0, g} + MARGIN;
        b_plus = {1'b0, b} + MARGIN;
        hit = '0;
        hit[FLAG_RED]   = (r > thr_red) && ({1'b0, r} > g_plus) && ({1'b0, r} > b_plus);
        hit[FLAG_WHITE] = (r > thr_white) && (g > thr_white) && (b > thr_white);
        hit[FLAG_BLACK] = (r < thr_black) && (g < thr_black) && (b < thr_black);
    end

endmodule

// File: rtl/tricolor_pixel_sorter.sv
module tricolor_pixel_sorter
    import tricolor_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int RED_BASE   = 77,
    parameter int WHITE_BASE = 108,
    parameter int BLACK_BASE = 122,
    parameter int RED_MARGIN = 17,
    parameter int DARK_LIM   = 125,
    parameter int LIGHT_LIM  = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [PIX_W-1:0] avg_in,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    output logic             flags_valid,
    output logic [2:0]       flags
);

    corr_mode_e           mode;
    logic [PIX_W-1:0]     corr;
    logic [PIX_W-1:0]     thr_red, thr_white, thr_black;
    logic [NUM_FLAGS-1:0] hit;

    brightness_mode_fsm #(
        .PIX_W     (PIX_W),
        .DARK_LIM  (DARK_LIM),
        .LIGHT_LIM (LIGHT_LIM)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .avg_in      (avg_in),
        .mode        (mode),
        .corr        (corr)
    );

    threshold_shift #(
        .PIX_W      (PIX_W),
        .RED_BASE   (RED_BASE),
        .WHITE_BASE (WHITE_BASE),
        .BLACK_BASE (BLACK_BASE)
    ) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .corr      (corr),
        .thr_red   (thr_red),
        .thr_white (thr_white),
        .thr_black (thr_black)
    );

    color_match #(
        .PIX_W      (PIX_W),
        .RED_MARGIN (RED_MARGIN)
    ) u_match (
        .r         (pix_r),
        .g         (pix_g),
        .b         (pix_b),
        .thr_red   (thr_red),
        .thr_white (thr_white),
        .thr_black (thr_black),
        .hit       (hit)
    );

    // Output register: one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_valid <= 1'b0;
            flags       <= '0;
        end else begin
            flags_valid <= pix_valid;
            flags       <= pix_valid ? hit : '0;
        end
    end

    // R7: valid tracks the input valid one cycle later
    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> flags_valid);

    // R7: an idle cycle yields an empty, invalid result
    p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !flags_valid && flags == 3'b000);

    // R3: a pixel bright enough to be whitish at base level cannot be blackish in lighten mode unless both thresholds straddle it
    p_black_white_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_valid && flags[FLAG_WHITE] && flags[FLAG_BLACK]) |-> $past(thr_white) < $past(thr_black));

endmodule

// File: tb/tricolor_pixel_sorter_tb.sv
module tricolor_pixel_sorter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] avg_in = '0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       flags_valid;
    logic [2:0] flags;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    int m_mode = 0;   // 0 none, 1 darken, 2 lighten
    int m_corr = 0;
    int exp_valid = 0;
    int exp_flags = 0;
    int lcg = 12345;

    always #4 clk = ~clk;   // 125 MHz

    tricolor_pixel_sorter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .avg_in      (avg_in),
        .pix_valid   (pix_valid),
        .pix_r       (pix_r),
        .pix_g       (pix_g),
        .pix_b       (pix_b),
        .flags_valid (flags_valid),
        .flags       (flags)
    );

    function automatic int clamp(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int shifted(input int base);
        if (m_mode == 1) return clamp(base - m_corr);
        if (m_mode == 2) return clamp(base + m_corr);
        return base;
    endfunction

    function automatic int model(input int r, input int g, input int b);
        int tr, tw, tb, f;
        tr = shifted(77);
        tw = shifted(108);
        tb = shifted(122);
        f = 0;
        if (r > tr && r - g > 17 && r - b > 17) f = f | 1;
        if (r > tw && g > tw && b > tw)         f = f | 2;
        if (r < tb && g < tb && b < tb)         f = f | 4;
        return f;
    endfunction

    // One clock: drive at negedge, predict, clock, compare at the next negedge
    task automatic step(input bit fs, input int avg, input bit v,
                        input int r, input int g, input int b, input string req);
        frame_start = fs;
        avg_in      = avg[7:0];
        pix_valid   = v;
        pix_r       = r[7:0];
        pix_g       = g[7:0];
        pix_b       = b[7:0];
        exp_valid   = v ? 1 : 0;
        exp_flags   = v ? model(r, g, b) : 0;
        if (fs) begin
            if (avg < 125) begin
                m_mode = 1; m_corr = 125 - avg;
            end else if (avg > 150) begin
                m_mode = 2; m_corr = avg - 150;
            end else begin
                m_mode = 0; m_corr = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (int'(flags_valid) != exp_valid || int'(flags) != exp_flags) begin
            errors++;
            $display("FAIL %s: valid=%0d flags=%b expected valid=%0d flags=%b",
                     req, flags_valid, flags, exp_valid, exp_flags[2:0]);
        end
    endtask

    task automatic pix(input int r, input int g, input int b, input string req);
        step(0, 0, 1, r, g, b, req);
    endtask

    task automatic new_frame(input int avg, input string req);
        step(1, avg, 0, 0, 0, 0, req);
    endtask

    task automatic sweep(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int r, g, b;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            r = (lcg >> 4) & 255;
            g = (lcg >> 12) & 255;
            b = (lcg >> 20) & 255;
            step(0, 0, ((lcg >> 2) & 3) != 0, r, g, b, req);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        checks++;
        if (flags_valid !== 1'b0 || flags !== 3'b000) begin
            errors++;
            $display("FAIL R8: valid=%0d flags=%b expected valid=0 flags=000", flags_valid, flags);
        end
        rst_n = 1'b1;
        // R8: neutral after reset, no frame_start yet
        pix(78, 60, 60, "R8");
        // R1 boundaries at neutral
        pix(78, 60, 60, "R1");
        pix(77, 50, 50, "R1");
        pix(100, 83, 50, "R1");
        pix(100, 82, 82, "R1");
        pix(255, 0, 0, "R1");
        // R2 boundaries
        pix(109, 109, 109, "R2");
        pix(108, 200, 200, "R2");
        // R3 boundaries and overlap
        pix(121, 121, 121, "R3");
        pix(122, 0, 0, "R3");
        pix(0, 0, 0, "R3");
        // R7: bubbles
        step(0, 0, 0, 255, 255, 255, "R7");
        pix(200, 200, 200, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");
        sweep(40, "R7");
        // R5: darken, mean 100 -> thresholds 52/83/97
        new_frame(100, "R4");
        pix(53, 30, 30, "R5");
        pix(52, 30, 30, "R5");
        pix(84, 84, 84, "R5");
        pix(97, 97, 97, "R5");
        pix(96, 96, 96, "R5");
        sweep(40, "R5");
        // R5: darken with clamping, mean 0
        new_frame(0, "R4");
        pix(18, 0, 0, "R5");
        pix(1, 1, 1, "R5");
        pix(0, 0, 0, "R5");
        sweep(30, "R5");
        // R6: lighten, mean 200 -> thresholds 127/158/172
        new_frame(200, "R4");
        pix(128, 100, 100, "R6");
        pix(127, 100, 100, "R6");
        pix(159, 159, 159, "R6");
        pix(158, 200, 200, "R6");
        pix(171, 171, 171, "R6");
        sweep(40, "R6");
        new_frame(255, "R6");
        pix(183, 0, 0, "R6");
        pix(228, 226, 226, "R6");
        sweep(30, "R6");
        // R4: band edges remain neutral
        new_frame(125, "R4");
        pix(78, 60, 60, "R4");
        pix(121, 121, 121, "R4");
        new_frame(150, "R4");
        pix(109, 109, 109, "R4");
        new_frame(124, "R4");
        pix(77, 50, 50, "R4");
        new_frame(151, "R4");
        pix(78, 50, 50, "R4");
        // R4: frame_start together with a valid pixel uses the old mode
        step(1, 0, 1, 60, 30, 30, "R4");
        pix(60, 30, 30, "R4");
        sweep(30, "R4");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule